// File: doc/BRIEF.md
# Bidirectional RGB / YCbCr Colour Converter

This block converts 24-bit pixels between the RGB and YCbCr colour spaces, one pixel per clock, through a fixed eight-register pipeline. A direction input picks the forward path (RGB side in, YCbCr side out) or the inverse path (YCbCr side in, RGB side out). A range input picks one of two fixed coefficient sets. One set suits studio-swing video. The other uses the full 8-bit code range. Every control input is captured with the pixel it comes with, so the mode may change on any pixel without corrupting pixels that are still in flight.

A subtractive-primary option treats the RGB-side bus as cyan, magenta and yellow. Each of these is the 8-bit complement of red, green and blue. In the forward path the complement is taken before the matrix, and in the inverse path it is taken after the clamp. A bypass option copies the selected source bus to the destination bus unchanged, with the same latency. The two sides are modelled as separate input and output buses. Each output bus has an enable flag for an external pad driver.

Top module: `csc_core`

## Requirements
- R1: Forward, full range: with R, G, B the components of the RGB-side input, Y = rnd(306R+601G+117B), Cb = rnd(−173R−339G+512B)+128, Cr = rnd(512R−429G−83B)+128, where rnd(x) = floor((x+512)/1024) (Q10 coefficients, half rounded up).
- R2: Forward, studio range: Y = rnd(263R+516G+100B)+16, Cb = rnd(−152R−298G+450B)+128, Cr = rnd(450R−377G−73B)+128.
- R3: Inverse, full range: with y = Y, u = Cb−128, v = Cr−128: R = rnd(1024y+1436v), G = rnd(1024y−352u−731v), B = rnd(1024y+1815u).
- R4: Inverse, studio range: with y = Y−16, u = Cb−128, v = Cr−128: R = rnd(1192y+1634v), G = rnd(1192y−401u−833v), B = rnd(1192y+2066u).
- R5: Results are clamped after rounding. Studio-range forward output is clamped to Y in 16..235 and Cb/Cr in 16..240. All other outputs are clamped to 0..255.
- R6: With cmy_mode set, the RGB-side bus carries Cy = 255−R, Ma = 255−G and Ye = 255−B. In the forward path the inputs are complemented before the matrix. In the inverse path the clamped outputs are complemented.
- R7: With bypass set, the destination bus carries the source bus unchanged, after the same latency. Range and cmy_mode then have no effect.
- R8: A pixel presented before clock edge n appears at the outputs after edge n+7 (eight registers). Throughput is one pixel per clock. direction, full_range, cmy_mode and bypass apply to the pixel presented with them.
- R9: Bus layout on both sides: bits [23:16] are R/Y, bits [15:8] are G/Cb and bits [7:0] are B/Cr. rgb_oe = out_en AND (pixel at the output is inverse). ycc_oe = out_en AND (pixel at the output is forward). A bus whose enable is low reads zero. After reset the pipeline holds a zero forward pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| direction | input | 1 | 0: RGB to YCbCr, 1: YCbCr to RGB |
| full_range | input | 1 | 0: studio coefficient set, 1: full-range set |
| cmy_mode | input | 1 | RGB side carries complemented primaries |
| bypass | input | 1 | Pass the source pixel through unchanged |
| out_en | input | 1 | Global output enable for the pad drivers |
| rgb_in | input | 24 | RGB-side input pixel |
| ycc_in | input | 24 | YCbCr-side input pixel |
| rgb_out | output | 24 | RGB-side output pixel |
| rgb_oe | output | 1 | RGB-side driver enable |
| ycc_out | output | 24 | YCbCr-side output pixel |
| ycc_oe | output | 1 | YCbCr-side driver enable |

## Verification
Control bits travel through their own delay line beside the data. If a mode bit is misaligned by even one stage, the error shows at the ports as soon as the mode changes. The bench changes the mode on every pixel, so such a fault shows within the first few pixels after the pipeline fills. A wrong coefficient, a wrong offset or a wrong rounding constant shifts one component by at least one code. The sweep uses component values on both sides of each clamp limit, so a wrong limit shows as a component that saturates one code early or late. A fault in the enable logic shows as a non-zero bus or an enable pin at the wrong level, on the first cycle it occurs.

// File: rtl/csc_pkg.sv
// Shared constants, types and coefficient tables for the colour converter.
// Assumes 8-bit components and Q10 coefficients; widths below follow from them.
package csc_pkg;
    localparam int PIX_W  = 8;
    localparam int BUS_W  = 3 * PIX_W;
    localparam int FRAC_W = 10;
    localparam int COEF_W = 13;
    localparam int OPD_W  = PIX_W + 2;
    localparam int PROD_W = COEF_W + OPD_W;
    localparam int ACC_W  = PROD_W + 2;
    localparam int RND_W  = ACC_W - FRAC_W;
    localparam int OFF_W  = RND_W + 1;
    localparam int PIX_MAX = (1 << PIX_W) - 1;
    localparam int CHROMA_MID = 1 << (PIX_W - 1);
    localparam int STUDIO_BLACK = 16;

    typedef struct packed {
        logic inv;
        logic full;
        logic cmy;
        logic byp;
    } csc_ctrl_t;

    typedef struct packed {
        csc_ctrl_t          ctrl;
        logic [BUS_W-1:0]   pix;
    } csc_side_t;

    // Matrix coefficient for output row and operand column in the chosen mode.
    function automatic int coef(input logic inv, input logic full, input int row, input int col);
        int t [9];
        case ({inv, full})
            2'b01:   t = '{306, 601, 117, -173, -339, 512, 512, -429, -83};
            2'b00:   t = '{263, 516, 100, -152, -298, 450, 450, -377, -73};
            2'b11:   t = '{1024, 0, 1436, 1024, -352, -731, 1024, 1815, 0};
            default: t = '{1192, 0, 1634, 1192, -401, -833, 1192, 2066, 0};
        endcase
        return t[row * 3 + col];
    endfunction
endpackage

// File: rtl/csc_delay.sv
// Tapped shift register: carries a word along the pipeline and exposes every stage.
// Assumes DEPTH >= 1; tap 0 is one register after the input.
module csc_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [W-1:0]              d_i,
    output logic [DEPTH-1:0][W-1:0]   tap_o
);
    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        if (k == 0) begin : g_first
            // Load the first stage from the input.
            always_ff @(posedge clk) begin
                if (!rst_n) tap_o[k] <= '0;
                else        tap_o[k] <= d_i;
            end
        end else begin : g_next
            // Shift each later stage from its predecessor.
            always_ff @(posedge clk) begin
                if (!rst_n) tap_o[k] <= '0;
                else        tap_o[k] <= tap_o[k-1];
            end
        end
    end
endmodule

// File: rtl/csc_prep.sv
// Operand preparation (combinational): splits the source pixel into three signed
// operands, complementing primaries in the forward subtractive mode and removing
// black level and chroma midpoint in the inverse mode.
module csc_prep
    import csc_pkg::*;
(
    input  csc_ctrl_t                 ctrl_i,
    input  logic [BUS_W-1:0]          pix_i,
    output logic signed [OPD_W-1:0]   opd_o [3]
);
    // Derive each operand from its component.
    always_comb begin
        for (int i = 0; i < 3; i++) begin
            int c;
            int v;
            c = int'(pix_i[(2-i)*PIX_W +: PIX_W]);
            if (!ctrl_i.inv) begin
                v = ctrl_i.cmy ? (PIX_MAX - c) : c;
            end else if (i == 0) begin
                v = c - (ctrl_i.full ? 0 : STUDIO_BLACK);
            end else begin
                v = c - CHROMA_MID;
            end
            opd_o[i] = OPD_W'(v);
        end
    end
endmodule

// File: rtl/csc_matrix.sv
// Three-register 3x3 matrix: products, row sums, then round-half-up and shift.
// Assumes operands and control arrive aligned; control picks the coefficient set.
module csc_matrix
    import csc_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  csc_ctrl_t                 ctrl_i,
    input  logic signed [OPD_W-1:0]   opd_i [3],
    output logic signed [RND_W-1:0]   rnd_o [3]
);
    localparam int HALF = 1 << (FRAC_W - 1);

    logic signed [COEF_W-1:0] coef_sel [3][3];
    logic signed [PROD_W-1:0] prod_q   [3][3];
    logic signed [ACC_W-1:0]  acc_q    [3];
    logic signed [ACC_W-1:0]  rsum     [3];

    // Pick the coefficient set for the current operands.
    always_comb begin
        for (int r = 0; r < 3; r++)
            for (int c = 0; c < 3; c++)
                coef_sel[r][c] = COEF_W'(coef(ctrl_i.inv, ctrl_i.full, r, c));
    end

    for (genvar r = 0; r < 3; r++) begin : g_row
        for (genvar c = 0; c < 3; c++) begin : g_col
            // Register one product.
            always_ff @(posedge clk) begin
                if (!rst_n) prod_q[r][c] <= '0;
                else        prod_q[r][c] <= PROD_W'(opd_i[c]) * PROD_W'(coef_sel[r][c]);
            end
        end

        // Register the row sum.
        always_ff @(posedge clk) begin
            if (!rst_n) acc_q[r] <= '0;
            else        acc_q[r] <= ACC_W'(prod_q[r][0]) + ACC_W'(prod_q[r][1]) + ACC_W'(prod_q[r][2]);
        end

        // Add the rounding half.
        always_comb rsum[r] = acc_q[r] + ACC_W'(HALF);

        // Register the rounded integer result.
        always_ff @(posedge clk) begin
            if (!rst_n) rnd_o[r] <= '0;
            else        rnd_o[r] <= RND_W'(rsum[r] >>> FRAC_W);
        end
    end
endmodule

// File: rtl/csc_post.sv
// Two-register output stage: adds the output offsets, then clamps to the legal range
// and complements primaries for the inverse subtractive mode.
// Assumes ctrl5_i is aligned with rnd_i and ctrl6_i with the offset register.
module csc_post
    import csc_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  csc_ctrl_t                 ctrl5_i,
    input  csc_ctrl_t                 ctrl6_i,
    input  logic signed [RND_W-1:0]   rnd_i [3],
    output logic [BUS_W-1:0]          res_o
);
    logic signed [OFF_W-1:0] off_q [3];
    logic [BUS_W-1:0]        res_d;

    // Register each component with its output offset added.
    always_ff @(posedge clk) begin
        for (int r = 0; r < 3; r++) begin
            int ofs;
            if (ctrl5_i.inv)  ofs = 0;
            else if (r != 0)  ofs = CHROMA_MID;
            else              ofs = ctrl5_i.full ? 0 : STUDIO_BLACK;
            if (!rst_n) off_q[r] <= '0;
            else        off_q[r] <= OFF_W'(int'(rnd_i[r]) + ofs);
        end
    end

    // Clamp each component and apply the inverse complement.
    always_comb begin
        for (int r = 0; r < 3; r++) begin
            int v;
            int lo;
            int hi;
            lo = 0;
            hi = PIX_MAX;
            if (!ctrl6_i.inv && !ctrl6_i.full) begin
                lo = STUDIO_BLACK;
                hi = (r == 0) ? 235 : 240;
            end
            v = int'(off_q[r]);
            if (v < lo) v = lo;
            if (v > hi) v = hi;
            if (ctrl6_i.inv && ctrl6_i.cmy) v = PIX_MAX - v;
            res_d[(2-r)*PIX_W +: PIX_W] = PIX_W'(v);
        end
    end

    // Register the clamped pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) res_o <= '0;
        else        res_o <= res_d;
    end
endmodule

// File: rtl/csc_core.sv
// Top of the bidirectional colour converter. Eight registers from input to output:
// capture, operands, products, sums, rounding, offset, clamp, output select.
// Assumes the external pad logic uses rgb_oe / ycc_oe; disabled buses read zero.
module csc_core
    import csc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              direction,
    input  logic              full_range,
    input  logic              cmy_mode,
    input  logic              bypass,
    input  logic              out_en,
    input  logic [23:0]       rgb_in,
    input  logic [23:0]       ycc_in,
    output logic [23:0]       rgb_out,
    output logic              rgb_oe,
    output logic [23:0]       ycc_out,
    output logic              ycc_oe
);
    localparam int SIDE_W     = $bits(csc_side_t);
    localparam int SIDE_DEPTH = 6;

    csc_side_t                        side_s1;
    logic [SIDE_DEPTH-1:0][SIDE_W-1:0] side_tap;
    csc_side_t                        side_s2, side_s5, side_s6, side_s7;
    logic signed [OPD_W-1:0]          opd_d  [3];
    logic signed [OPD_W-1:0]          opd_s2 [3];
    logic signed [RND_W-1:0]          rnd_s5 [3];
    logic [BUS_W-1:0]                 res_s7;
    logic [BUS_W-1:0]                 out_q;
    logic                             out_inv_q;

    // Capture the mode bits and the selected source bus.
    always_ff @(posedge clk) begin
        if (!rst_n) side_s1 <= '0;
        else begin
            side_s1.ctrl <= '{inv: direction, full: full_range, cmy: cmy_mode, byp: bypass};
            side_s1.pix  <= direction ? ycc_in : rgb_in;
        end
    end

    csc_delay #(.W(SIDE_W), .DEPTH(SIDE_DEPTH)) i_side (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (side_s1),
        .tap_o (side_tap)
    );

    assign side_s2 = csc_side_t'(side_tap[0]);
    assign side_s5 = csc_side_t'(side_tap[3]);
    assign side_s6 = csc_side_t'(side_tap[4]);
    assign side_s7 = csc_side_t'(side_tap[5]);

    csc_prep i_prep (
        .ctrl_i (side_s1.ctrl),
        .pix_i  (side_s1.pix),
        .opd_o  (opd_d)
    );

    // Register the prepared operands.
    always_ff @(posedge clk) begin
        for (int i = 0; i < 3; i++) begin
            if (!rst_n) opd_s2[i] <= '0;
            else        opd_s2[i] <= opd_d[i];
        end
    end

    csc_matrix i_matrix (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctrl_i (side_s2.ctrl),
        .opd_i  (opd_s2),
        .rnd_o  (rnd_s5)
    );

    csc_post i_post (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl5_i (side_s5.ctrl),
        .ctrl6_i (side_s6.ctrl),
        .rnd_i   (rnd_s5),
        .res_o   (res_s7)
    );

    // Register the output pixel, choosing the raw source in bypass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q     <= '0;
            out_inv_q <= 1'b0;
        end else begin
            out_q     <= side_s7.ctrl.byp ? side_s7.pix : res_s7;
            out_inv_q <= side_s7.ctrl.inv;
        end
    end

    // Drive the enables and gate each bus with its enable.
    always_comb begin
        rgb_oe  = out_en & out_inv_q;
        ycc_oe  = out_en & ~out_inv_q;
        rgb_out = rgb_oe ? out_q : '0;
        ycc_out = ycc_oe ? out_q : '0;
    end
endmodule

// File: rtl/csc_core_chk.sv
// Port-level checker for csc_core, attached by bind. Uses only the top's ports
// and a saturating count of cycles since reset to gate history-based properties.
module csc_core_chk (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        direction,
    input  logic        full_range,
    input  logic        cmy_mode,
    input  logic        bypass,
    input  logic        out_en,
    input  logic [23:0] rgb_in,
    input  logic [23:0] ycc_in,
    input  logic [23:0] rgb_out,
    input  logic        rgb_oe,
    input  logic [23:0] ycc_out,
    input  logic        ycc_oe
);
    logic [3:0] since_rst;

    // Count clock edges since reset, saturating at the pipeline depth.
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst < 4'd8) since_rst <= since_rst + 4'd1;
    end

    // R9: the two drivers are never enabled together.
    assert_oe_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rgb_oe && ycc_oe));

    // R9: a disabled output stage keeps both buses and enables low.
    assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (rgb_out == '0 && ycc_out == '0 && !rgb_oe && !ycc_oe));

    // R8: the enabled side follows the direction given eight edges earlier.
    assert_oe_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 4'd8) |-> (ycc_oe == (out_en && !$past(direction, 8))));

    // R7: forward bypass reproduces the RGB-side input of eight edges earlier.
    assert_bypass_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 4'd8 && out_en && $past(bypass, 8) && !$past(direction, 8))
        |-> (ycc_out == $past(rgb_in, 8)));

    // R5: studio forward results stay inside the studio code range.
    assert_studio_limits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 4'd8 && out_en && !$past(bypass, 8) && !$past(direction, 8)
         && !$past(full_range, 8))
        |-> (ycc_out[23:16] >= 8'd16 && ycc_out[23:16] <= 8'd235 &&
             ycc_out[15:8]  >= 8'd16 && ycc_out[15:8]  <= 8'd240 &&
             ycc_out[7:0]   >= 8'd16 && ycc_out[7:0]   <= 8'd240));
endmodule

bind csc_core csc_core_chk i_chk (.*);

// File: tb/test_csc_core.sv
// Bench: streams every grid pixel under all sixteen mode combinations, changing the
// mode on every pixel, and compares each output against arithmetic from the requirements.
module test_csc_core;
    localparam int CLK_PERIOD = 10;
    localparam int NPIX       = 8192;
    localparam int LAT        = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        direction = 1'b0, full_range = 1'b0, cmy_mode = 1'b0, bypass = 1'b0;
    logic        out_en = 1'b1;
    logic [23:0] rgb_in = '0, ycc_in = '0;
    logic [23:0] rgb_out, ycc_out;
    logic        rgb_oe, ycc_oe;

    int checks = 0;
    int errors = 0;

    logic [23:0] exp_pix [NPIX];
    logic        exp_inv [NPIX];
    string       exp_tag [NPIX];

    always #(CLK_PERIOD/2) clk = ~clk;

    csc_core i_csc_core (
        .clk(clk), .rst_n(rst_n), .direction(direction), .full_range(full_range),
        .cmy_mode(cmy_mode), .bypass(bypass), .out_en(out_en),
        .rgb_in(rgb_in), .ycc_in(ycc_in),
        .rgb_out(rgb_out), .rgb_oe(rgb_oe), .ycc_out(ycc_out), .ycc_oe(ycc_oe)
    );

    function automatic int rnd(input int x);
        return (x + 512) >>> 10;
    endfunction

    function automatic int lim(input int x, input int lo, input int hi);
        return (x < lo) ? lo : ((x > hi) ? hi : x);
    endfunction

    // Reference result from the requirement formulas.
    function automatic logic [23:0] model(input logic inv, input logic full, input logic cmy,
                                          input logic byp, input logic [23:0] rgb,
                                          input logic [23:0] ycc);
        int a, b, c, o0, o1, o2, y, u, v;
        if (byp) return inv ? ycc : rgb;                                  // R7
        if (!inv) begin
            a = rgb[23:16]; b = rgb[15:8]; c = rgb[7:0];
            if (cmy) begin a = 255 - a; b = 255 - b; c = 255 - c; end   // R6
            if (full) begin                                              // R1
                o0 = lim(rnd(306*a + 601*b + 117*c), 0, 255);
                o1 = lim(rnd(-173*a - 339*b + 512*c) + 128, 0, 255);
                o2 = lim(rnd(512*a - 429*b - 83*c) + 128, 0, 255);
            end else begin                                               // R2, R5
                o0 = lim(rnd(263*a + 516*b + 100*c) + 16, 16, 235);
                o1 = lim(rnd(-152*a - 298*b + 450*c) + 128, 16, 240);
                o2 = lim(rnd(450*a - 377*b - 73*c) + 128, 16, 240);
            end
        end else begin
            y = int'(ycc[23:16]) - (full ? 0 : 16);
            u = int'(ycc[15:8]) - 128;
            v = int'(ycc[7:0]) - 128;
            if (full) begin                                              // R3
                o0 = lim(rnd(1024*y + 1436*v), 0, 255);
                o1 = lim(rnd(1024*y - 352*u - 731*v), 0, 255);
                o2 = lim(rnd(1024*y + 1815*u), 0, 255);
            end else begin                                               // R4
                o0 = lim(rnd(1192*y + 1634*v), 0, 255);
                o1 = lim(rnd(1192*y - 401*u - 833*v), 0, 255);
                o2 = lim(rnd(1192*y + 2066*u), 0, 255);
            end
            if (cmy) begin o0 = 255 - o0; o1 = 255 - o1; o2 = 255 - o2; end  // R6
        end
        return {o0[7:0], o1[7:0], o2[7:0]};
    endfunction

    function automatic logic [7:0] grid(input int k);
        case (k)
            0: return 8'd0;   1: return 8'd15;  2: return 8'd16;  3: return 8'd100;
            4: return 8'd127; 5: return 8'd128; 6: return 8'd235; default: return 8'd255;
        endcase
    endfunction

    task automatic check(input string req, input logic [24:0] act, input logic [24:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as one failed check and still reports.
    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R9: reset state is a zero forward pixel, YCbCr side enabled.
        check("R9 reset", {ycc_oe, ycc_out}, {1'b1, 24'h0});
        check("R9 reset rgb", {rgb_oe, rgb_out}, {1'b0, 24'h0});
        rst_n = 1'b1;

        // R1 R2 R3 R4 R5 R6 R7 R8: mode changes every pixel, latency of LAT edges.
        for (int i = 0; i < NPIX + LAT; i++) begin
            @(negedge clk);
            if (i >= LAT) begin
                int p;
                p = i - LAT;
                check(exp_tag[p], {rgb_oe, rgb_out}, {exp_inv[p], exp_inv[p] ? exp_pix[p] : 24'h0});
                check({exp_tag[p], " R9"}, {ycc_oe, ycc_out}, {!exp_inv[p], exp_inv[p] ? 24'h0 : exp_pix[p]});
            end
            if (i < NPIX) begin
                logic [3:0] m;
                int g;
                m = 4'(i % 16);
                g = i / 16;
                direction  = m[0];
                full_range = m[1];
                cmy_mode   = m[2];
                bypass     = m[3];
                rgb_in = {grid(g % 8), grid((g / 8) % 8), grid(g / 64)};
                ycc_in = {grid(g / 64), grid(g % 8), grid((g / 8) % 8)};
                exp_pix[i] = model(m[0], m[1], m[2], m[3], rgb_in, ycc_in);
                exp_inv[i] = m[0];
                if (m[3])      exp_tag[i] = "R7 R8";
                else if (m[0]) exp_tag[i] = m[1] ? "R3 R5 R8" : "R4 R5 R8";
                else           exp_tag[i] = m[1] ? "R1 R5 R8" : "R2 R5 R8";
                if (m[2] && !m[3]) exp_tag[i] = {exp_tag[i], " R6"};
            end else begin
                rgb_in = '0; ycc_in = '0; bypass = 1'b0; direction = 1'b0;
            end
        end

        // R9: dropping the global enable silences both sides at once.
        @(negedge clk);
        out_en = 1'b0;
        #1;
        check("R9 disabled", {rgb_oe, ycc_oe, rgb_out[22:0]}, 25'h0);
        check("R9 disabled ycc", {1'b0, ycc_out}, 25'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule